// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt inputs and turns them into two request lines and one wake line. Each input has a three-bit trigger code that picks one of these behaviours: off, rising edge, falling edge, either edge, active-high level or active-low level. Each input also has an enable (mask) bit, a wake-enable bit and a routing bit that sends it to one of the two request lines. Edge events are held in two capture words, one for rising and one for falling transitions, until software writes ones to clear them. Level sources are not held and track the synchronized input.

Software changes every setting through a pair of addresses. One address sets the bits written as one and the other clears them, so no read-modify-write is needed. Two read-only words give the active enabled sources for each request line. These words sit at the same offsets as two clear-only write ports. All inputs pass through a two-stage synchronizer before any detection. The bus is a plain single-cycle register port. A write takes effect at the clock edge on which `bus_we_i` is high, and read data is a combinational function of `bus_addr_i`.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, all three trigger-code words, the enable, routing and wake-enable words and both capture words read zero. The source word at 0x58 reads all ones, the scratch word at 0x80 reads zero, and all three outputs are low.
- R2: Each settable word is written as ones to its set address and cleared by writing ones to the address 4 above it. Only the bits written as one change, and the word is read back at its set address. The set addresses are: code bit 0 at 0x40, code bit 1 at 0x48, code bit 2 at 0x50, source at 0x58, routing at 0x60, wake enable at 0x68 and enable at 0x70.
- R3: For input i, the trigger code is {word@0x50[i], word@0x48[i], word@0x40[i]}. The codes are 001 rising, 010 falling, 011 both edges, 101 high level and 110 low level. Codes 000, 100 and 111 capture nothing and raise nothing.
- R4: A qualifying transition on `src_i[i]` sets bit i of the rising capture word (read at 0x78) or of the falling capture word (read at 0x7C). The bit becomes visible after the third rising clock edge following the input change, and not after the second.
- R5: Writing ones to 0x78 or 0x7C clears those bits of the rising or falling capture word. A clear wins over an edge event being captured on the same clock edge.
- R6: In level mode, the input's contribution to pending follows the synchronized input two clock edges after the input changes, and it is never latched.
- R7: Pending bit i is (rising capture | falling capture | active level condition) AND enable bit i. A disabled source still records edges in the capture words.
- R8: The word read at 0x54 is pending AND routing, and the word read at 0x5C is pending AND NOT routing. `req0_o` and `req1_o` are the OR of the bits of the respective word.
- R9: `wake_o` is high exactly when some pending bit also has its wake-enable bit set.
- R10: Writing ones to the enable clear address 0x74 clears the same bits in both the enable word and the wake-enable word.
- R11: The scratch word at 0x80 is written whole and read back whole, and it has no effect on any output.
- R12: At the shared offsets 0x54 and 0x5C, reads return the pending words. Writes there clear bits of code bit 2 and of the source word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | N | Write data, one bit per source |
| bus_rdata_o | output | N | Read data for `bus_addr_i` |
| src_i | input | N | Asynchronous interrupt inputs |
| req0_o | output | 1 | Request line for sources routed with routing bit 1 |
| req1_o | output | 1 | Request line for sources routed with routing bit 0 |
| wake_o | output | 1 | Pending source with wake enable set |

## Verification
Two functions can fall on the same clock edge: the capture of a freshly synchronized edge and a software write-one-to-clear of that capture bit. The bench changes an input and then times the clear write so that it is sampled on the third clock edge after the change. That is exactly the edge on which the capture would otherwise be recorded. The bench then judges that the capture word reads zero afterwards, and that the per-cycle reference model agrees with the request, wake and read-data outputs throughout. A second overlap is the enable-clear write, which must drop the wake enable on the same edge. This is judged through the wake-enable word and `wake_o`.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

  // settable words, each with a set offset and a clear offset 4 above it
  localparam int NUM_SC  = 7;
  localparam int RG_CFG0 = 0;
  localparam int RG_CFG1 = 1;
  localparam int RG_CFG2 = 2;
  localparam int RG_SRC  = 3;
  localparam int RG_ASG  = 4;
  localparam int RG_WAKE = 5;
  localparam int RG_MASK = 6;

  localparam logic [7:0] OFS_PEND0 = 8'h54;
  localparam logic [7:0] OFS_PEND1 = 8'h5C;
  localparam logic [7:0] OFS_RCAP  = 8'h78;
  localparam logic [7:0] OFS_FCAP  = 8'h7C;
  localparam logic [7:0] OFS_TEST  = 8'h80;

  // trigger codes, bit 2 from code word 2 down to bit 0 from code word 0
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_HIGH = 3'b101;
  localparam logic [2:0] TRG_LOW  = 3'b110;

  typedef struct packed {
    logic rise_en;
    logic fall_en;
    logic hi_en;
    logic lo_en;
  } trig_sel_t;

  function automatic logic [7:0] sc_set_ofs(int k);
    return 8'h40 + 8'(k * 8);
  endfunction

  function automatic logic [7:0] sc_clr_ofs(int k);
    return sc_set_ofs(k) + 8'h04;
  endfunction

  function automatic trig_sel_t decode_trig(logic [2:0] code);
    trig_sel_t s;
    s = '0;
    case (code)
      TRG_RISE: s.rise_en = 1'b1;
      TRG_FALL: s.fall_en = 1'b1;
      TRG_BOTH: begin s.rise_en = 1'b1; s.fall_en = 1'b1; end
      TRG_HIGH: s.hi_en = 1'b1;
      TRG_LOW:  s.lo_en = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  // per input: two synchronizer stages plus one history stage
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], src_i[b]};
    end
    assign lvl_o[b]  = sh_q[1];
    assign rise_o[b] = sh_q[1] & ~sh_q[2];
    assign fall_o[b] = ~sh_q[1] & sh_q[2];
  end

endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import trig_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] c0_i,
  input  logic [N-1:0] c1_i,
  input  logic [N-1:0] c2_i,
  output logic [N-1:0] rise_en_o,
  output logic [N-1:0] fall_en_o,
  output logic [N-1:0] hi_en_o,
  output logic [N-1:0] lo_en_o
);

  for (genvar b = 0; b < N; b++) begin : g_dec
    trig_sel_t sel;
    assign sel          = decode_trig({c2_i[b], c1_i[b], c0_i[b]});
    assign rise_en_o[b] = sel.rise_en;
    assign fall_en_o[b] = sel.fall_en;
    assign hi_en_o[b]   = sel.hi_en;
    assign lo_en_o[b]   = sel.lo_en;
  end

endmodule

// File: rtl/trig_regfile.sv
module trig_regfile
  import trig_irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [N-1:0]                 wdata_i,
  input  logic [N-1:0]                 rise_evt_i,
  input  logic [N-1:0]                 fall_evt_i,
  output logic [NUM_SC-1:0][N-1:0]     sc_o,
  output logic [N-1:0]                 rcap_o,
  output logic [N-1:0]                 fcap_o,
  output logic [N-1:0]                 test_o
);

  logic mask_clr_hit;
  logic rcap_clr_hit;
  logic fcap_clr_hit;
  logic test_hit;

  assign mask_clr_hit = we_i && (addr_i == ADDR_W'(sc_clr_ofs(RG_MASK)));
  assign rcap_clr_hit = we_i && (addr_i == ADDR_W'(OFS_RCAP));
  assign fcap_clr_hit = we_i && (addr_i == ADDR_W'(OFS_FCAP));
  assign test_hit     = we_i && (addr_i == ADDR_W'(OFS_TEST));

  for (genvar k = 0; k < NUM_SC; k++) begin : g_sc
    localparam logic [N-1:0] RST_VAL = {N{1'(k == RG_SRC)}};
    logic         set_hit;
    logic         clr_hit;
    logic [N-1:0] q;

    assign set_hit = we_i && (addr_i == ADDR_W'(sc_set_ofs(k)));
    // the wake-enable word is also cleared by the enable clear port
    assign clr_hit = (we_i && (addr_i == ADDR_W'(sc_clr_ofs(k))))
                   || ((k == RG_WAKE) && mask_clr_hit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= RST_VAL;
      else if (set_hit) q <= q | wdata_i;
      else if (clr_hit) q <= q & ~wdata_i;
    end
    assign sc_o[k] = q;
  end

  // capture words: new events are OR-ed in, then a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcap_o <= '0;
      fcap_o <= '0;
    end else begin
      rcap_o <= (rcap_o | rise_evt_i) & ~(rcap_clr_hit ? wdata_i : '0);
      fcap_o <= (fcap_o | fall_evt_i) & ~(fcap_clr_hit ? wdata_i : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       test_o <= '0;
    else if (test_hit) test_o <= wdata_i;
  end

endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
  parameter int N = 32
) (
  input  logic [N-1:0] rcap_i,
  input  logic [N-1:0] fcap_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] hi_en_i,
  input  logic [N-1:0] lo_en_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] asg_i,
  input  logic [N-1:0] wen_i,
  output logic [N-1:0] pend0_o,
  output logic [N-1:0] pend1_o,
  output logic         req0_o,
  output logic         req1_o,
  output logic         wake_o
);

  logic [N-1:0] cond;
  logic [N-1:0] pend;

  for (genvar b = 0; b < N; b++) begin : g_cond
    assign cond[b] = rcap_i[b] | fcap_i[b]
                   | (hi_en_i[b] & lvl_i[b])
                   | (lo_en_i[b] & ~lvl_i[b]);
  end

  assign pend    = cond & mask_i;
  assign pend0_o = pend & asg_i;
  assign pend1_o = pend & ~asg_i;
  assign req0_o  = |pend0_o;
  assign req1_o  = |pend1_o;
  assign wake_o  = |(pend & wen_i);

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N-1:0]      bus_wdata_i,
  output logic [N-1:0]      bus_rdata_o,
  input  logic [N-1:0]      src_i,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);

  logic [NUM_SC-1:0][N-1:0] sc;
  logic [N-1:0] mask_q, asg_q, wake_q;
  logic [N-1:0] rcap_q, fcap_q, test_q;
  logic [N-1:0] lvl, rise_raw, fall_raw;
  logic [N-1:0] rise_en, fall_en, hi_en, lo_en;
  logic [N-1:0] pend0, pend1;

  assign mask_q = sc[RG_MASK];
  assign asg_q  = sc[RG_ASG];
  assign wake_q = sc[RG_WAKE];

  trig_sync_edge #(.N(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .lvl_o  (lvl),
    .rise_o (rise_raw),
    .fall_o (fall_raw)
  );

  trig_decode #(.N(N)) u_dec (
    .c0_i      (sc[RG_CFG0]),
    .c1_i      (sc[RG_CFG1]),
    .c2_i      (sc[RG_CFG2]),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .hi_en_o   (hi_en),
    .lo_en_o   (lo_en)
  );

  trig_regfile #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rise_evt_i (rise_raw & rise_en),
    .fall_evt_i (fall_raw & fall_en),
    .sc_o       (sc),
    .rcap_o     (rcap_q),
    .fcap_o     (fcap_q),
    .test_o     (test_q)
  );

  trig_pend #(.N(N)) u_pend (
    .rcap_i  (rcap_q),
    .fcap_i  (fcap_q),
    .lvl_i   (lvl),
    .hi_en_i (hi_en),
    .lo_en_i (lo_en),
    .mask_i  (mask_q),
    .asg_i   (asg_q),
    .wen_i   (wake_q),
    .pend0_o (pend0),
    .pend1_o (pend1),
    .req0_o  (req0_o),
    .req1_o  (req1_o),
    .wake_o  (wake_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < NUM_SC; k++) begin
      if (bus_addr_i == ADDR_W'(sc_set_ofs(k))) bus_rdata_o = sc[k];
    end
    if (bus_addr_i == ADDR_W'(OFS_PEND0)) bus_rdata_o = pend0;
    if (bus_addr_i == ADDR_W'(OFS_PEND1)) bus_rdata_o = pend1;
    if (bus_addr_i == ADDR_W'(OFS_RCAP))  bus_rdata_o = rcap_q;
    if (bus_addr_i == ADDR_W'(OFS_FCAP))  bus_rdata_o = fcap_q;
    if (bus_addr_i == ADDR_W'(OFS_TEST))  bus_rdata_o = test_q;
  end

endmodule

// File: rtl/trig_irq_chk.sv
module trig_irq_chk
  import trig_irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic              req0_i,
  input logic              req1_i,
  input logic              wake_i,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      asg_q,
  input logic [N-1:0]      wake_q,
  input logic [N-1:0]      rcap_q,
  input logic [N-1:0]      rise_en
);

  assert_set_alias_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(sc_set_ofs(RG_MASK)))
      |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  assert_capture_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rcap_q & ~$past(rcap_q) & ~$past(rise_en)) == '0));

  assert_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_RCAP)) |=> ((rcap_q & $past(wdata_i)) == '0));

  assert_req0_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req0_i |-> ((mask_q & asg_q) != '0));

  assert_req1_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req1_i |-> ((mask_q & ~asg_q) != '0));

  assert_wake_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> ((mask_q & wake_q) != '0));

  assert_mask_clr_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(sc_clr_ofs(RG_MASK))) |=> ((wake_q & $past(wdata_i)) == '0));

endmodule

bind trig_irq_ctrl trig_irq_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (bus_we_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .req0_i  (req0_o),
  .req1_i  (req1_o),
  .wake_i  (wake_o),
  .mask_q  (mask_q),
  .asg_q   (asg_q),
  .wake_q  (wake_q),
  .rcap_q  (rcap_q),
  .rise_en (rise_en)
);

// File: tb/trig_irq_ctrl_test.sv
module trig_irq_ctrl_test;
  localparam int N     = 32;
  localparam int AW    = 8;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  src = '0;
  logic [N-1:0]  rdata;
  logic          req0, req1, wk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  trig_irq_ctrl #(.N(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src),
    .req0_o(req0), .req1_o(req1), .wake_o(wk)
  );

  // behavioural reference state
  logic [N-1:0] m_s1, m_s2, m_s3, m_c0, m_c1, m_c2, m_src;
  logic [N-1:0] m_asg, m_wake, m_mask, m_rc, m_fc, m_test;

  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0] nrc, nfc;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_c0 = '0; m_c1 = '0; m_c2 = '0; m_src = '1;
      m_asg = '0; m_wake = '0; m_mask = '0;
      m_rc = '0; m_fc = '0; m_test = '0;
    end else begin
      nrc = m_rc;
      nfc = m_fc;
      for (int i = 0; i < N; i++) begin
        int code;
        code = {m_c2[i], m_c1[i], m_c0[i]};
        if (m_s2[i] && !m_s3[i] && (code == 1 || code == 3)) nrc[i] = 1'b1;
        if (!m_s2[i] && m_s3[i] && (code == 2 || code == 3)) nfc[i] = 1'b1;
      end
      if (we) begin
        case (addr)
          8'h40: m_c0 |= wdata;   8'h44: m_c0 &= ~wdata;
          8'h48: m_c1 |= wdata;   8'h4C: m_c1 &= ~wdata;
          8'h50: m_c2 |= wdata;   8'h54: m_c2 &= ~wdata;
          8'h58: m_src |= wdata;  8'h5C: m_src &= ~wdata;
          8'h60: m_asg |= wdata;  8'h64: m_asg &= ~wdata;
          8'h68: m_wake |= wdata; 8'h6C: m_wake &= ~wdata;
          8'h70: m_mask |= wdata;
          8'h74: begin m_mask &= ~wdata; m_wake &= ~wdata; end
          8'h78: nrc &= ~wdata;
          8'h7C: nfc &= ~wdata;
          8'h80: m_test = wdata;
          default: ;
        endcase
      end
      m_rc = nrc; m_fc = nfc;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
    end
  end

  function automatic logic [N-1:0] m_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) begin
      int  code;
      logic lv;
      code = {m_c2[i], m_c1[i], m_c0[i]};
      lv = (code == 5 && m_s2[i]) || (code == 6 && !m_s2[i]);
      p[i] = (m_rc[i] | m_fc[i] | lv) & m_mask[i];
    end
    return p;
  endfunction

  function automatic logic [N-1:0] m_read(logic [AW-1:0] a);
    case (a)
      8'h40: return m_c0;   8'h48: return m_c1;  8'h50: return m_c2;
      8'h54: return m_pend() & m_asg;
      8'h58: return m_src;
      8'h5C: return m_pend() & ~m_asg;
      8'h60: return m_asg;  8'h68: return m_wake; 8'h70: return m_mask;
      8'h78: return m_rc;   8'h7C: return m_fc;   8'h80: return m_test;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison a quarter period after each active edge
  always @(posedge clk) begin
    if (rst_n && !done) begin
      #(CLK_P/4);
      chk("R8 req0", N'(req0), N'(|(m_pend() & m_asg)));
      chk("R8 req1", N'(req1), N'(|(m_pend() & ~m_asg)));
      chk("R9 wake", N'(wk), N'(|(m_pend() & m_wake)));
      chk("R2 rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [N-1:0] exp, string tag);
    @(negedge clk); addr = a;
    @(posedge clk); #(CLK_P/4);
    chk(tag, rdata, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h58, 32'hFFFF_FFFF, "R1 source word");
    rd(8'h70, 32'h0, "R1 enable word");
    rd(8'h78, 32'h0, "R1 rise capture");
    rd(8'h80, 32'h0, "R1 scratch");
    chk("R1 outputs", N'({req0, req1, wk}), '0);
    // R2 set and clear aliases
    wr(8'h70, 32'h0000_00F0);
    wr(8'h74, 32'h0000_0030);
    rd(8'h70, 32'h0000_00C0, "R2 enable set/clear");
    wr(8'h74, 32'h0000_00C0);
    // R12 shared offset: write clears source, read gives pending
    wr(8'h5C, 32'h0000_FFFF);
    rd(8'h58, 32'hFFFF_0000, "R12 source clear at shared offset");
    rd(8'h5C, 32'h0, "R12 pending-1 read");
    // R4 rising edge on source 0 routed to req0
    wr(8'h40, 32'h1); wr(8'h60, 32'h1); wr(8'h70, 32'h1);
    @(negedge clk); src[0] = 1'b1;
    rd(8'h78, 32'h0, "R4 not yet captured");
    rd(8'h78, 32'h1, "R4 captured third edge");
    chk("R8 req0 from rise", N'(req0), N'(1));
    rd(8'h54, 32'h1, "R8 pending-0 word");
    // R5 clear
    wr(8'h78, 32'h1);
    rd(8'h78, 32'h0, "R5 rise clear");
    chk("R5 req0 dropped", N'(req0), N'(0));
    @(negedge clk); src[0] = 1'b0;
    step(4);
    rd(8'h7C, 32'h0, "R3 rising mode ignores fall");
    // R3 falling source 1, routed to req1
    wr(8'h48, 32'h2); wr(8'h70, 32'h2);
    @(negedge clk); src[1] = 1'b1;
    step(4);
    rd(8'h78, 32'h0, "R3 falling mode ignores rise");
    @(negedge clk); src[1] = 1'b0;
    step(4);
    rd(8'h7C, 32'h2, "R3 falling captured");
    rd(8'h5C, 32'h2, "R8 pending-1 word");
    chk("R8 req1 from fall", N'(req1), N'(1));
    wr(8'h7C, 32'h2);
    // R3 both edges on disabled source 2, R7 capture without pending
    wr(8'h40, 32'h4); wr(8'h48, 32'h4);
    @(negedge clk); src[2] = 1'b1;
    step(4);
    rd(8'h78, 32'h4, "R3 both: rise");
    @(negedge clk); src[2] = 1'b0;
    step(4);
    rd(8'h7C, 32'h4, "R3 both: fall");
    rd(8'h5C, 32'h0, "R7 disabled source not pending");
    wr(8'h78, 32'h4); wr(8'h7C, 32'h4);
    // R6 high level on source 3 to req0
    wr(8'h50, 32'h8); wr(8'h40, 32'h8); wr(8'h70, 32'h8); wr(8'h60, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    rd(8'h54, 32'h8, "R6 high level after two edges");
    @(negedge clk); src[3] = 1'b0;
    rd(8'h54, 32'h0, "R6 level not latched");
    // R6 low level on source 4 to req1
    wr(8'h50, 32'h10); wr(8'h48, 32'h10); wr(8'h70, 32'h10);
    rd(8'h5C, 32'h10, "R6 low level pending");
    @(negedge clk); src[4] = 1'b1;
    rd(8'h5C, 32'h0, "R6 low level released");
    wr(8'h74, 32'h10);
    // R3 code 111 on source 5 is disabled
    wr(8'h40, 32'h20); wr(8'h48, 32'h20); wr(8'h50, 32'h20); wr(8'h70, 32'h20);
    @(negedge clk); src[5] = 1'b1;
    step(4);
    @(negedge clk); src[5] = 1'b0;
    step(4);
    rd(8'h78, 32'h0, "R3 code 111 no rise");
    rd(8'h7C, 32'h0, "R3 code 111 no fall");
    rd(8'h5C, 32'h0, "R3 code 111 no pending");
    // R9 wake from high-level source 3
    wr(8'h68, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    step(3);
    chk("R9 wake asserted", N'(wk), N'(1));
    // R10 enable clear drops wake enable
    wr(8'h74, 32'h8);
    rd(8'h68, 32'h0, "R10 wake enable cleared");
    chk("R10 wake low", N'(wk), N'(0));
    rd(8'h70, 32'h23, "R10 enable word");
    // R11 scratch word
    wr(8'h80, 32'hA5A5_5A5A);
    rd(8'h80, 32'hA5A5_5A5A, "R11 scratch readback");
    chk("R11 outputs untouched", N'({req0, req1, wk}), '0);
    // R5 clear on the same edge as a new capture, source 6
    wr(8'h40, 32'h40); wr(8'h70, 32'h40);
    @(negedge clk); src[6] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 8'h78; wdata = 32'h40;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(8'h78, 32'h0, "R5 clear wins over event");
    chk("R5 req0 after race", N'(req0), N'(0));
    step(2);
    finish_run();
  end

endmodule